// File: doc/BRIEF.md
# Accumulator ALU with Per-Operation Flag Masking

This block is the arithmetic and logic core of a small accumulator-style processor. It combines a register operand with a memory operand (or works on the register operand alone) under a 5-bit operation code. It produces a 16-bit result in the same cycle, along with a write-back qualifier. It also keeps a four-bit status register holding negative, zero, overflow and carry. The six unary operations are invert, negate, arithmetic shift left, arithmetic shift right, rotate left through carry and rotate right through carry. The five binary operations are add, subtract, AND, OR and compare.

Each operation owns a fixed set of flags it may change. When the update strobe is high, only that set is loaded from the newly computed values. Every other flag keeps its previous value. Compare produces the same flags as subtract but lowers the write-back qualifier, so the surrounding datapath leaves the register untouched.

Flag updates use a plain strobe rather than a valid/ready pair. The block never stalls, so it applies no back-pressure. A strobe is accepted on every rising clock edge at which it is high.

Top module: `acc_alu_flagmask`

## Requirements
- R1: While `rst_n` is low, `flags` reads 0. `flags` is ordered {N, Z, V, C}, with N in bit 3 and C in bit 0.
- R2: On an edge where `upd_en` is low, `flags` keeps its value, whatever the operation code.
- R3: Add (code 8) outputs `reg_opnd + mem_opnd` modulo 2^16 and loads N, Z, V and C. C is the carry out of bit 15, and V is set when the signed sum is out of range.
- R4: Subtract (code 9) outputs `reg_opnd - mem_opnd`, computed as the register operand plus the inverted memory operand plus 1, and loads all four flags. C is the carry out of that sum, so C=1 means no borrow; V flags signed overflow.
- R5: Compare (code 12) loads the same four flags as subtract, and `res_wr` is 0.
- R6: AND (code 10) and OR (code 11) output the bitwise result and load only N and Z. V and C hold.
- R7: Invert (code 0) outputs the bitwise complement of `reg_opnd` and loads only N and Z.
- R8: Negate (code 1) outputs the two's complement of `reg_opnd` and loads N, Z and V, with V set only for input 0x8000, whose result is 0x8000. C holds.
- R9: Arithmetic shift left (code 2) shifts in a 0 and loads all four flags. C takes the old bit 15, and V is old bit 15 XOR old bit 14.
- R10: Arithmetic shift right (code 3) replicates bit 15 and loads N, Z and C, with C taking the old bit 0. V holds.
- R11: Rotate left (code 4) moves the current C into bit 0 and the old bit 15 into C. Rotate right (code 5) moves C into bit 15 and the old bit 0 into C. Both load only C, so N, Z and V hold.
- R12: Any other code outputs `reg_opnd` unchanged, holds `res_wr` at 0 and changes no flag.
- R13: `res_wr` is 1 for codes 0 to 5 and 8 to 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the status flags |
| op_sel | input | 5 | Operation code |
| reg_opnd | input | 16 | Register operand; the only source for unary operations |
| mem_opnd | input | 16 | Second operand for binary operations |
| upd_en | input | 1 | Strobe that loads the masked flags at the next rising edge |
| res | output | 16 | Combinational result |
| res_wr | output | 1 | High when the result should be written back to the register |
| flags | output | 4 | Status register {N, Z, V, C} |

## Verification
`res` and `res_wr` are combinational, so they are due in the same cycle the operands and code are applied. The flags they produce appear on `flags` only after the next rising edge, and only if `upd_en` was high. The bench therefore drives each operation on a falling edge and compares `res` and `res_wr` 1 ns later. It compares `flags` at the next falling edge, against a reference model that advanced its own flag state at the edge in between. Rotates read the carry held before the edge, and the model reads its own carry the same way, so that dependency is checked cycle for cycle.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OP_W   = 5;
  localparam int FLAG_W = 4;

  // flag bit positions inside the status vector
  localparam int FB_N = 3;
  localparam int FB_Z = 2;
  localparam int FB_V = 1;
  localparam int FB_C = 0;

  typedef enum logic [OP_W-1:0] {
    OP_INV = 5'd0,
    OP_NEG = 5'd1,
    OP_ASL = 5'd2,
    OP_ASR = 5'd3,
    OP_ROL = 5'd4,
    OP_ROR = 5'd5,
    OP_ADD = 5'd8,
    OP_SUB = 5'd9,
    OP_AND = 5'd10,
    OP_OR  = 5'd11,
    OP_CMP = 5'd12
  } alu_op_e;

  // which flags an operation is permitted to load, ordered {N,Z,V,C}
  function automatic logic [FLAG_W-1:0] flag_mask(input logic [OP_W-1:0] op);
    logic [FLAG_W-1:0] m;
    case (op)
      OP_ADD, OP_SUB, OP_CMP, OP_ASL: m = 4'b1111;
      OP_AND, OP_OR, OP_INV:          m = 4'b1100;
      OP_NEG:                         m = 4'b1110;
      OP_ASR:                         m = 4'b1101;
      OP_ROL, OP_ROR:                 m = 4'b0001;
      default:                        m = 4'b0000;
    endcase
    return m;
  endfunction

  function automatic logic is_unary(input logic [OP_W-1:0] op);
    return (op == OP_INV) || (op == OP_NEG) || (op == OP_ASL) ||
           (op == OP_ASR) || (op == OP_ROL) || (op == OP_ROR);
  endfunction

  function automatic logic is_binary(input logic [OP_W-1:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
           (op == OP_OR)  || (op == OP_CMP);
  endfunction

  // result goes back to the register for every defined op except compare
  function automatic logic commits_result(input logic [OP_W-1:0] op);
    return is_unary(op) || (is_binary(op) && (op != OP_CMP));
  endfunction

endpackage

// File: rtl/acc_alu_unary.sv
module acc_alu_unary
  import acc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic            cin,
  output logic [W-1:0]    y,
  output logic            v,
  output logic            c
);

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    y = a;
    v = 1'b0;
    c = cin;
    case (op)
      OP_INV: y = ~a;
      OP_NEG: begin
        y = '0 - a;
        v = (a == MOST_NEG);
      end
      OP_ASL: begin
        y = {a[W-2:0], 1'b0};
        v = a[W-1] ^ a[W-2];
        c = a[W-1];
      end
      OP_ASR: begin
        y = {a[W-1], a[W-1:1]};
        c = a[0];
      end
      OP_ROL: begin
        y = {a[W-2:0], cin};
        c = a[W-1];
      end
      OP_ROR: begin
        y = {cin, a[W-1:1]};
        c = a[0];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_alu_binary.sv
module acc_alu_binary
  import acc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    y,
  output logic            v,
  output logic            c
);

  logic         sub;
  logic [W-1:0] b_in;
  logic [W:0]   sum;

  // one adder serves add, subtract and compare
  always_comb begin
    sub  = (op == OP_SUB) || (op == OP_CMP);
    b_in = sub ? ~b : b;
    sum  = {1'b0, a} + {1'b0, b_in} + {{W{1'b0}}, sub};
    c    = sum[W];
    v    = (a[W-1] == b_in[W-1]) && (sum[W-1] != a[W-1]);
    case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      default: y = sum[W-1:0];
    endcase
  end

endmodule

// File: rtl/acc_alu_flagreg.sv
module acc_alu_flagreg
  import acc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [FLAG_W-1:0] mask,
  input  logic [FLAG_W-1:0] nxt,
  output logic [FLAG_W-1:0] q
);

  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[i] <= 1'b0;
      else if (en && mask[i])
        q[i] <= nxt[i];
    end
  end

endmodule

// File: rtl/acc_alu_flagmask.sv
module acc_alu_flagmask
  import acc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [W-1:0]      reg_opnd,
  input  logic [W-1:0]      mem_opnd,
  input  logic              upd_en,
  output logic [W-1:0]      res,
  output logic              res_wr,
  output logic [FLAG_W-1:0] flags
);

  logic [W-1:0]      un_y, bin_y;
  logic              un_v, un_c, bin_v, bin_c;
  logic              v_sel, c_sel;
  logic [FLAG_W-1:0] flag_nxt;
  logic [FLAG_W-1:0] flag_en_mask;

  acc_alu_unary #(.W(W)) u_unary (
    .op  (op_sel),
    .a   (reg_opnd),
    .cin (flags[FB_C]),
    .y   (un_y),
    .v   (un_v),
    .c   (un_c)
  );

  acc_alu_binary #(.W(W)) u_binary (
    .op (op_sel),
    .a  (reg_opnd),
    .b  (mem_opnd),
    .y  (bin_y),
    .v  (bin_v),
    .c  (bin_c)
  );

  always_comb begin
    if (is_unary(op_sel)) begin
      res   = un_y;
      v_sel = un_v;
      c_sel = un_c;
    end else if (is_binary(op_sel)) begin
      res   = bin_y;
      v_sel = bin_v;
      c_sel = bin_c;
    end else begin
      res   = reg_opnd;
      v_sel = 1'b0;
      c_sel = 1'b0;
    end
    flag_nxt[FB_N] = res[W-1];
    flag_nxt[FB_Z] = (res == '0);
    flag_nxt[FB_V] = v_sel;
    flag_nxt[FB_C] = c_sel;
    flag_en_mask   = flag_mask(op_sel);
    res_wr         = commits_result(op_sel);
  end

  acc_alu_flagreg u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (upd_en),
    .mask  (flag_en_mask),
    .nxt   (flag_nxt),
    .q     (flags)
  );

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [OP_W-1:0]   op_sel,
  input logic [W-1:0]      reg_opnd,
  input logic              upd_en,
  input logic [W-1:0]      res,
  input logic              res_wr,
  input logic [FLAG_W-1:0] flags
);

  logic defined_op;
  assign defined_op = is_unary(op_sel) || is_binary(op_sel);

  always @(posedge clk) begin
    if (!rst_n) assert_reset_clear_R1: assert (flags == '0);
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(flags));

  assert_add_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_sel == OP_ADD) |=> (flags[FB_Z] == ($past(res) == '0)));

  assert_sub_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_sel == OP_SUB) |=> (flags[FB_N] == $past(res[W-1])));

  assert_cmp_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_CMP) |-> !res_wr);

  assert_logic_vc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && (op_sel == OP_AND || op_sel == OP_OR)) |=>
      (flags[FB_V:FB_C] == $past(flags[FB_V:FB_C])));

  assert_inv_vc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_sel == OP_INV) |=> (flags[FB_V:FB_C] == $past(flags[FB_V:FB_C])));

  assert_neg_c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_sel == OP_NEG) |=> (flags[FB_C] == $past(flags[FB_C])));

  assert_asl_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_sel == OP_ASL) |=> (flags[FB_C] == $past(reg_opnd[W-1])));

  assert_asr_v_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_sel == OP_ASR) |=> (flags[FB_V] == $past(flags[FB_V])));

  assert_rot_nzv_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && (op_sel == OP_ROL || op_sel == OP_ROR)) |=>
      (flags[FB_N:FB_V] == $past(flags[FB_N:FB_V])));

  assert_rol_fill_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_ROL) |-> (res[0] == flags[FB_C]));

  assert_undef_pass_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !defined_op |-> (!res_wr && res == reg_opnd));

  assert_undef_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !defined_op) |=> $stable(flags));

  assert_commit_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (defined_op && op_sel != OP_CMP) |-> res_wr);

endmodule

bind acc_alu_flagmask acc_alu_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_sel   (op_sel),
  .reg_opnd (reg_opnd),
  .upd_en   (upd_en),
  .res      (res),
  .res_wr   (res_wr),
  .flags    (flags)
);

// File: tb/tb_acc_alu_flagmask.sv
`timescale 1ns/1ps
module tb_acc_alu_flagmask;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op_sel = 5'd0;
  logic [15:0] reg_opnd = 16'h0;
  logic [15:0] mem_opnd = 16'h0;
  logic        upd_en = 1'b0;
  logic [15:0] res;
  logic        res_wr;
  logic [3:0]  flags;

  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;
  logic [3:0] mf = 4'h0;   // model flags {N,Z,V,C}
  string ftag = "R1";

  always #2.5 clk = ~clk;

  acc_alu_flagmask dut (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .reg_opnd(reg_opnd),
    .mem_opnd(mem_opnd), .upd_en(upd_en), .res(res), .res_wr(res_wr),
    .flags(flags)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: result, write-back and the flag state after a strobe
  function automatic void ref_op(input logic [4:0] op, input logic [15:0] a,
                                 input logic [15:0] b, input logic [3:0] f,
                                 output logic [15:0] r, output logic wr,
                                 output logic [3:0] nf, output string tag);
    int sa, sb, ua, ub, t;
    bit nz;
    sa = $signed(a); sb = $signed(b); ua = a; ub = b;
    nf = f; wr = 1'b1; r = a; nz = 1'b1; tag = "R12";
    case (op)
      5'd0: begin r = ~a; tag = "R7"; end
      5'd1: begin t = -sa; r = t[15:0]; nf[1] = (t > 32767); tag = "R8"; end
      5'd2: begin
        t = sa * 2; r = t[15:0];
        nf[1] = (t > 32767) || (t < -32768); nf[0] = a[15]; tag = "R9";
      end
      5'd3: begin t = sa >>> 1; r = t[15:0]; nf[0] = a[0]; tag = "R10"; end
      5'd4: begin r = {a[14:0], f[0]}; nf[0] = a[15]; nz = 1'b0; tag = "R11"; end
      5'd5: begin r = {f[0], a[15:1]}; nf[0] = a[0]; nz = 1'b0; tag = "R11"; end
      5'd8: begin
        t = ua + ub; r = t[15:0]; nf[0] = (t > 65535);
        t = sa + sb; nf[1] = (t > 32767) || (t < -32768); tag = "R3";
      end
      5'd9, 5'd12: begin
        t = ua + (65535 - ub) + 1; r = t[15:0]; nf[0] = (t > 65535);
        t = sa - sb; nf[1] = (t > 32767) || (t < -32768);
        if (op == 5'd12) begin wr = 1'b0; tag = "R5"; end else tag = "R4";
      end
      5'd10: begin r = a & b; tag = "R6"; end
      5'd11: begin r = a | b; tag = "R6"; end
      default: begin wr = 1'b0; nz = 1'b0; end
    endcase
    if (nz) begin nf[3] = r[15]; nf[2] = (r == 16'h0); end
  endfunction

  task automatic step(input logic [4:0] op, input logic [15:0] a,
                      input logic [15:0] b, input logic en);
    logic [15:0] er; logic ew; logic [3:0] ef; string t, wt;
    @(negedge clk);
    op_sel = op; reg_opnd = a; mem_opnd = b; upd_en = en;
    #1;
    chk(flags == mf, ftag, "flags", {12'h0, flags}, {12'h0, mf});
    ref_op(op, a, b, mf, er, ew, ef, t);
    chk(res == er, t, "result", res, er);
    wt = (t == "R5" || t == "R12") ? t : "R13";
    chk(res_wr == ew, wt, "res_wr", {15'h0, res_wr}, {15'h0, ew});
    if (en) begin mf = ef; ftag = t; end
    else ftag = "R2";
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: flags clear under reset, even with an active strobe
    op_sel = 5'd8; reg_opnd = 16'hffff; mem_opnd = 16'h0001; upd_en = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      chk(flags == 4'h0, "R1", "flags in reset", {12'h0, flags}, 16'h0);
    end
    @(negedge clk); rst_n = 1'b1; upd_en = 1'b0;

    step(5'd8, 16'h7fff, 16'h0001, 1'b1); // R3 signed overflow
    step(5'd8, 16'hffff, 16'h0001, 1'b1); // R3 carry and zero
    step(5'd10, 16'hf0f0, 16'h0ff0, 1'b1); // R6 V,C held
    step(5'd11, 16'h8000, 16'h0001, 1'b1); // R6
    step(5'd9, 16'h0005, 16'h0005, 1'b1); // R4 equal, no borrow
    step(5'd9, 16'h8000, 16'h0001, 1'b1); // R4 overflow
    step(5'd12, 16'h0003, 16'h0005, 1'b1); // R5 compare borrow
    step(5'd1, 16'h8000, 16'h0000, 1'b1); // R8 most negative
    step(5'd1, 16'h0000, 16'h0000, 1'b1); // R8 zero
    step(5'd2, 16'h4000, 16'h0000, 1'b1); // R9 V set
    step(5'd2, 16'h8000, 16'h0000, 1'b1); // R9 C set, zero
    step(5'd3, 16'h8001, 16'h0000, 1'b1); // R10
    step(5'd4, 16'h8000, 16'h0000, 1'b1); // R11 rotate in C
    step(5'd4, 16'h0001, 16'h0000, 1'b1); // R11
    step(5'd5, 16'h0001, 16'h0000, 1'b1); // R11
    step(5'd5, 16'h0002, 16'h0000, 1'b1); // R11
    step(5'd0, 16'hffff, 16'h0000, 1'b1); // R7
    step(5'd7, 16'h1234, 16'h5678, 1'b1); // R12 undefined code
    step(5'd15, 16'h0000, 16'h0000, 1'b1); // R12
    step(5'd8, 16'h8000, 16'h8000, 1'b0); // R2 no strobe
    step(5'd0, 16'h0000, 16'h0000, 1'b0); // R2

    for (int i = 0; i < 600; i++) begin
      logic [4:0]  o;
      logic [15:0] x, y;
      o = 5'($urandom_range(0, 15));
      x = (i % 7 == 0) ? 16'h8000 : 16'($urandom);
      y = (i % 11 == 0) ? 16'hffff : 16'($urandom);
      step(o, x, y, ($urandom_range(0, 3) != 0));
    end
    step(5'd6, 16'h0000, 16'h0000, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule